// File: doc/BRIEF.md
# Period-Match Interval Timer

This block is an 8-bit up-counting interval timer with a small register port. A count register climbs from zero and is compared with a period register on every cycle. When the count equals the period, the next counting step returns the count to zero instead of incrementing it. That step also emits a one-clock match strobe, which a neighbouring serial unit can use as its shift clock.

Counting steps come from an incoming clock-enable. The enable first passes through a 4-bit prescaler that divides it by 1, 4 or 16. Match events feed a 4-bit postscaler, which raises a sticky interrupt flag once for every group of 1 to 16 matches. A run bit in the control register starts and stops the timer.

The bus port decodes a 2-bit address. Address 0 is the count, address 1 is the period and address 2 is the control register. Reads are combinational.

Top module: `periodTimer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control register reads 00h, and both `intFlag` and `matchPulse` are 0.
- R2: A write to address 0 or 1 is read back unchanged from that address. On a control write, read back from address 2 returns the data with bit 7 forced to 0. Address 3 reads 00h.
- R3: The control register holds the prescale select in bits 1:0. With the run bit set and `tickEn` held high, the count advances once every 1 cycle for select 00, once every 4 cycles for 01, and once every 16 cycles for 10 or 11.
- R4: The step that follows a count equal to the period loads 00h into the count. That step drives `matchPulse` high for exactly that one cycle. A period of P therefore gives one match every P+1 steps.
- R5: The control register holds the postscale field N in bits 6:3. `intFlag` is set on every (N+1)-th match event after the postscaler was last cleared.
- R6: `intFlag` stays set until `intClr` is pulsed. A set and a clear in the same cycle leave the flag set.
- R7: The control register holds the run bit in bit 2. While the run bit is 0, or while `tickEn` is 0, the count holds its value and `matchPulse` stays 0.
- R8: A control write leaves the count unchanged. It clears the prescaler, so the next step needs a full prescale interval. It also clears the postscaler.
- R9: A count write takes priority over a step in the same cycle. It also clears the prescaler and the postscaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count clock enable, fed to the prescaler |
| busAddr | input | 2 | Register select: 0 count, 1 period, 2 control |
| busWrEn | input | 1 | Write strobe for the selected register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data of the selected register |
| intClr | input | 1 | Pulse to clear the interrupt flag |
| intFlag | output | 1 | Sticky postscaled interrupt flag |
| matchPulse | output | 1 | One-cycle strobe for each period match |

## Verification
The assertions assume that `busWrEn` is a clean one-cycle write that selects a single register. They also assume that the prescaler and postscaler limits change only through a control write. Such a write clears both counters in the same cycle. The stimulus keeps to these assumptions in two ways. It changes control fields only through bus writes. It issues every write with `tickEn` low, except where a write is deliberately made to collide with a counting step. Inputs change only on the falling clock edge, so no write is ever seen half-applied.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int PRESC_W   = 4;
  localparam int POST_W    = 4;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;

  typedef struct packed {
    logic [POST_W-1:0] postSel;   // bits 6:3
    logic              run;       // bit 2
    logic [1:0]        prescSel;  // bits 1:0
  } ctlReg_t;

  typedef struct packed {
    logic cntWrite;
    logic perWrite;
    logic ctlWrite;
    logic advance;
  } dpStrobe_t;

  function automatic logic [PRESC_W-1:0] prescLimitOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRESC_W'(0);
      2'b01:   return PRESC_W'(3);
      default: return PRESC_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per,
  output logic             isEqual
);
  localparam logic [CNT_W-1:0] PER_RESET = {CNT_W{1'b1}};

  assign isEqual = (cnt == per);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntWrite) begin
      cnt <= wrData;
    end else if (strobe.advance) begin
      cnt <= isEqual ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                per <= PER_RESET;
    else if (strobe.perWrite) per <= wrData;
  end

  // R4: a step taken at the period value lands on zero
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && isEqual && !strobe.cntWrite) |=> (cnt == '0));

  // R7: without a step or a write the count holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.cntWrite) |=> $stable(cnt));

  // R8: a control write keeps the count
  assert_ctl_keeps_cnt_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctlWrite |=> (cnt == $past(cnt)));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [6:0]        busWrData,
  input  logic              intClr,
  input  logic              isEqual,
  output dpStrobe_t         strobe,
  output ctlReg_t           ctl,
  output logic              matchPulse,
  output logic              intFlag
);
  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescLimit;
  logic [POST_W-1:0]  postCnt;
  logic               clearScalers;
  logic               prescTerminal;
  logic               matchEvent;
  logic               flagSet;

  always_comb begin
    strobe.cntWrite = busWrEn && (busAddr == ADDR_CNT);
    strobe.perWrite = busWrEn && (busAddr == ADDR_PER);
    strobe.ctlWrite = busWrEn && (busAddr == ADDR_CTL);
    clearScalers    = strobe.cntWrite || strobe.ctlWrite;
    prescLimit      = prescLimitOf(ctl.prescSel);
    prescTerminal   = (prescCnt == prescLimit);
    strobe.advance  = ctl.run && tickEn && prescTerminal && !clearScalers;
    matchEvent      = strobe.advance && isEqual;
    flagSet         = matchEvent && (postCnt == ctl.postSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                ctl <= '0;
    else if (strobe.ctlWrite) ctl <= ctlReg_t'(busWrData);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearScalers)        prescCnt <= '0;
    else if (ctl.run && tickEn)       prescCnt <= prescTerminal ? '0 : prescCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearScalers) postCnt <= '0;
    else if (matchEvent)       postCnt <= flagSet ? '0 : postCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPulse <= 1'b0;
      intFlag    <= 1'b0;
    end else begin
      matchPulse <= matchEvent;
      if (flagSet)     intFlag <= 1'b1;
      else if (intClr) intFlag <= 1'b0;
    end
  end

  // R3: prescaler never passes its selected limit
  assert_presc_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= prescLimit);

  // R5: postscaler never passes the postscale field
  assert_post_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    postCnt <= ctl.postSel);

  // R6: flag stays set without a clear
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !intClr) |=> intFlag);

  // R7: a stopped timer yields no match
  assert_no_match_stopped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run || !tickEn) |=> !matchPulse);
endmodule

// File: rtl/periodTimer.sv
module periodTimer
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              intClr,
  output logic              intFlag,
  output logic              matchPulse
);
  dpStrobe_t         strobe;
  ctlReg_t           ctl;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] per;
  logic              isEqual;

  timer_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData[6:0]),
    .intClr     (intClr),
    .isEqual    (isEqual),
    .strobe     (strobe),
    .ctl        (ctl),
    .matchPulse (matchPulse),
    .intFlag    (intFlag)
  );

  timer_datapath #(.CNT_W(DATA_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWrData),
    .cnt     (cnt),
    .per     (per),
    .isEqual (isEqual)
  );

  always_comb begin
    case (busAddr)
      ADDR_CNT: busRdData = cnt;
      ADDR_PER: busRdData = per;
      ADDR_CTL: busRdData = {1'b0, ctl};
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: tb/test_periodTimer.sv
module test_periodTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       intClr = 1'b0;
  logic       intFlag;
  logic       matchPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  periodTimer i_periodTimer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .intClr(intClr), .intFlag(intFlag), .matchPulse(matchPulse)
  );

  // period, prescSel, postSel, ticks, expected count, matches, flag
  typedef struct packed {
    logic [7:0]  per;
    logic [1:0]  presc;
    logic [3:0]  post;
    logic [15:0] ticks;
    logic [7:0]  expCnt;
    logic [7:0]  expHits;
    logic        expFlag;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd9,   2'b00, 4'd0, 16'd25,  8'd5,  8'd2, 1'b1},
    '{8'd4,   2'b01, 4'd2, 16'd40,  8'd0,  8'd2, 1'b0},
    '{8'd2,   2'b10, 4'd1, 16'd100, 8'd0,  8'd2, 1'b1},
    '{8'd2,   2'b11, 4'd0, 16'd47,  8'd2,  8'd0, 1'b0},
    '{8'd0,   2'b00, 4'd3, 16'd8,   8'd0,  8'd8, 1'b1},
    '{8'd255, 2'b00, 4'd0, 16'd300, 8'd44, 8'd1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic clearFlag();
    intClr = 1'b1;
    @(negedge clk);
    intClr = 1'b0;
  endtask

  function automatic logic [7:0] ctlWord(input logic [3:0] post, input logic run, input logic [1:0] ps);
    return {1'b0, post, run, ps};
  endfunction

  initial begin
    logic [7:0] rd;
    int hits;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd0, rd); check("R1 count", rd, 8'h00);
    busRead(2'd1, rd); check("R1 period", rd, 8'hFF);
    busRead(2'd2, rd); check("R1 control", rd, 8'h00);
    check("R1 flag", intFlag, 1'b0);
    check("R1 match", matchPulse, 1'b0);

    // R2 register access
    busWrite(2'd0, 8'hA5); busRead(2'd0, rd); check("R2 count rw", rd, 8'hA5);
    busWrite(2'd1, 8'h3C); busRead(2'd1, rd); check("R2 period rw", rd, 8'h3C);
    busWrite(2'd2, 8'hFF); busRead(2'd2, rd); check("R2 control bit7", rd, 8'h7F);
    busRead(2'd3, rd); check("R2 addr3", rd, 8'h00);

    // Table walk: R3 R4 R5
    foreach (VECS[i]) begin
      busWrite(2'd2, 8'h00);
      busWrite(2'd0, 8'h00);
      busWrite(2'd1, VECS[i].per);
      clearFlag();
      busWrite(2'd2, ctlWord(VECS[i].post, 1'b1, VECS[i].presc));
      hits = 0;
      tickEn = 1'b1;
      for (int k = 0; k < int'(VECS[i].ticks); k++) begin
        @(negedge clk);
        hits += int'(matchPulse);
      end
      tickEn = 1'b0;
      busRead(2'd0, rd);
      check($sformatf("R3 count vec%0d", i), rd, VECS[i].expCnt);
      check($sformatf("R4 matches vec%0d", i), hits, VECS[i].expHits);
      check($sformatf("R5 flag vec%0d", i), intFlag, VECS[i].expFlag);
    end

    // R7: run bit 0 holds count
    busWrite(2'd2, ctlWord(4'd0, 1'b0, 2'b00));
    busWrite(2'd0, 8'h10);
    tickEn = 1'b1;
    hits = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); hits += int'(matchPulse); end
    tickEn = 1'b0;
    busRead(2'd0, rd); check("R7 stopped count", rd, 8'h10);
    check("R7 stopped matches", hits, 0);

    // R8: control write keeps count, restarts prescaler
    busWrite(2'd1, 8'hFF);
    busWrite(2'd0, 8'h05);
    busWrite(2'd2, ctlWord(4'd0, 1'b1, 2'b01));
    tickEn = 1'b1;
    repeat (2) @(negedge clk);
    busWrite(2'd2, ctlWord(4'd0, 1'b1, 2'b01));
    busRead(2'd0, rd); check("R8 count kept", rd, 8'h05);
    repeat (3) @(negedge clk);
    busRead(2'd0, rd); check("R8 prescaler restarted", rd, 8'h05);
    @(negedge clk);
    busRead(2'd0, rd); check("R8 step after full interval", rd, 8'h06);
    tickEn = 1'b0;

    // R9: count write beats a step
    busWrite(2'd2, ctlWord(4'd0, 1'b1, 2'b00));
    tickEn = 1'b1;
    busWrite(2'd0, 8'h33);
    tickEn = 1'b0;
    busRead(2'd0, rd); check("R9 write priority", rd, 8'h33);

    // R6: sticky flag, clear, set wins over clear
    busWrite(2'd1, 8'h00);
    busWrite(2'd0, 8'h00);
    clearFlag();
    check("R6 cleared", intFlag, 1'b0);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    check("R6 set", intFlag, 1'b1);
    repeat (5) @(negedge clk);
    check("R6 sticky", intFlag, 1'b1);
    tickEn = 1'b1; intClr = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; intClr = 1'b0;
    check("R6 set beats clear", intFlag, 1'b1);
    clearFlag();
    check("R6 clear", intFlag, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule